// File: doc/BRIEF.md
# Serial-Peripheral Register Front End for a UART Channel

This block lets an SPI master control one UART channel through a small byte-wide register file. The master sends two bytes per frame: an address byte, whose top bit selects write or read, and a data byte. On a write the data byte lands in the addressed register. On a read the slave returns the addressed register on MISO during the second byte. One address serves as the data port. Writing it queues a byte for transmission, and reading it takes the oldest received byte. Both queues hold 128 bytes.

The serializer, baud engine and flow logic sit outside the block. They take bytes from the transmit queue and deliver received bytes through single-cycle strobes. They also report line, special-character, general and CTS-change events as pulses. These pulses collect in sticky status registers, and reading a status register clears it. A master interrupt status byte is masked by an enable byte and drives an active-low interrupt pin. The SPI pins are oversampled in the system clock domain, so the system clock must run well above the serial clock; at least eight times faster is a safe margin.

Top module: `uart_spi_bridge`

## Requirements
- R1: A frame uses SPI mode 0 and is 16 bits long, MSB first. Bit 7 of the first byte is 1 for a write and 0 for a read, and bits 6:0 give the register address. For a read, the register value is shifted out on MISO during the second byte, MSB first. Registers 0x01 (interrupt enable) and 0x10 (trigger) read back the last value written to them.
- R2: A write to address 0x00 appends the data byte to the transmit queue. The queue head is on `tx_data_o` whenever `tx_valid_o` is 1, and each `tx_take_i` pulse removes the head, so bytes leave in the order they were written.
- R3: A read of address 0x00 returns the oldest byte delivered by `rx_put_i` and removes it from the receive queue.
- R4: A read of address 0x00 while the receive queue is empty returns 0x00 and leaves the receive level at 0.
- R5: Address 0x11 reads the transmit queue level and 0x12 reads the receive queue level, each from 0 to 128. A write to a full transmit queue is dropped.
- R6: Writes to the read-only addresses 0x02, 0x06, 0x08, 0x11 and 0x12 change nothing. Reads of unassigned addresses return 0x00.
- R7: The status registers at 0x02, 0x06 and 0x08 are cleared by the read that returns them.
- R8: Status register 0x02 has these bits: 0 line event, 1 any special-character event, 2 any general event, 3 receive trigger, 4 transmit trigger, 5 transmit queue became empty, 6 receive queue became empty, 7 CTS change. Register 0x06 collects `spc_evt_i` bitwise, and register 0x08 collects `gen_evt_i` bitwise.
- R9: `irq_n_o` is low exactly while some bit is set both in 0x02 and in the enable register 0x01.
- R10: In trigger register 0x10, bits 3:0 (T) set the transmit trigger and bits 7:4 (R) set the receive trigger, both in units of 8 bytes. A value of 0 disables that trigger. Status bit 3 sets when the receive level becomes at least 8·R. Status bit 4 sets when the transmit level becomes at most 8·T.
- R11: While bit 1 of the mode register 0x0a is 1, both queues are held empty, and the bit reads back as written.
- R12: Writing 0x0a with bit 0 set returns every register to its reset value and empties both queues. Bit 0 always reads as 0.
- R13: If chip select rises before the 16th bit of a frame, the frame is discarded and causes no write.
- R14: After reset `irq_n_o` is 1, `tx_valid_o` is 0, and both levels and all status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| tx_data_o | output | 8 | Head byte of the transmit queue |
| tx_valid_o | output | 1 | Transmit queue holds at least one byte |
| tx_take_i | input | 1 | Pulse: serializer consumed the head byte |
| rx_data_i | input | 8 | Received byte from the line side |
| rx_put_i | input | 1 | Pulse: store `rx_data_i` into the receive queue |
| line_evt_i | input | 1 | Pulse: line-status event |
| spc_evt_i | input | 8 | Pulses: special-character events |
| gen_evt_i | input | 8 | Pulses: general status events |
| cts_evt_i | input | 1 | Pulse: CTS input changed |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The embedded properties check on every cycle that queue occupancy never exceeds its depth, that a push into a full queue or a pop from an empty one leaves the level unchanged, and that a queue clear leaves the level at zero. They also check that read and write strobes fire only at the 8th and 16th bit of a frame and never together, that a status read with no new event leaves the register clear, and that a soft reset restores the defaults. Behaviours that need whole transactions are left to the bench scenarios: byte ordering through both queues, the serial bit order on MISO, trigger thresholds, interrupt masking, an aborted frame, and data dropped at the full boundary.

// File: rtl/uart_spi_pkg.sv
package uart_spi_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_W     = BYTE_W - 1;
    localparam int unsigned FRAME_BITS = 2 * BYTE_W;
    localparam int unsigned TRIG_SH    = 3;   // trigger nibble counts 8-byte units

    localparam logic [ADDR_W-1:0] A_DATA    = 7'h00;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 7'h01;
    localparam logic [ADDR_W-1:0] A_IRQ_STS = 7'h02;
    localparam logic [ADDR_W-1:0] A_SPC_STS = 7'h06;
    localparam logic [ADDR_W-1:0] A_GEN_STS = 7'h08;
    localparam logic [ADDR_W-1:0] A_MODE    = 7'h0a;
    localparam logic [ADDR_W-1:0] A_TRIG    = 7'h10;
    localparam logic [ADDR_W-1:0] A_TX_LVL  = 7'h11;
    localparam logic [ADDR_W-1:0] A_RX_LVL  = 7'h12;

    localparam int unsigned MB_SOFT_RST = 0;
    localparam int unsigned MB_FIFO_CLR = 1;
endpackage

// File: rtl/uart_spi_fifo.sv
module uart_spi_fifo #(
    parameter  int unsigned WIDTH = 8,
    parameter  int unsigned DEPTH = 128,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop, is_full, is_empty;

    assign is_full  = (st_q.cnt == CNT_W'(DEPTH));
    assign is_empty = (st_q.cnt == '0);
    assign do_push  = push_i && !clr_i && !is_full;
    assign do_pop   = pop_i  && !clr_i && !is_empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = bump(st_q.wptr);
            if (do_pop)  st_d.rptr = bump(st_q.rptr);
            if (do_push && !do_pop) st_d.cnt = st_q.cnt + 1'b1;
            if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= din_i;
    end

    assign dout_o = mem[st_q.rptr];
    assign cnt_o  = st_q.cnt;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && is_full && !pop_i && !clr_i) |=> (st_q.cnt == CNT_W'(DEPTH)));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && is_empty && !push_i && !clr_i) |=> (st_q.cnt == '0));
    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/uart_spi_frontend.sv
module uart_spi_frontend
    import uart_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              rd_stb_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    input  logic [BYTE_W-1:0] rdata_i
);
    localparam int unsigned BC_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [2:0]        sclk_s;
        logic [1:0]        cs_s;
        logic [1:0]        mosi_s;
        logic [BC_W-1:0]   bitcnt;
        logic [BYTE_W-2:0] shin;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic [BYTE_W-1:0] shout;
        logic              miso;
        logic              rd_stb;
        logic              wr_stb;
    } fe_state_t;

    localparam fe_state_t FE_RST = '{sclk_s: '0, cs_s: 2'b11, mosi_s: '0, bitcnt: '0,
                                     shin: '0, addr: '0, wdata: '0, shout: '0,
                                     miso: 1'b0, rd_stb: 1'b0, wr_stb: 1'b0};

    fe_state_t fe_d, fe_q;
    logic sck_rise, sck_fall, selected, mosi_b;

    assign sck_rise = fe_q.sclk_s[1] & ~fe_q.sclk_s[2];
    assign sck_fall = ~fe_q.sclk_s[1] & fe_q.sclk_s[2];
    assign selected = ~fe_q.cs_s[1];
    assign mosi_b   = fe_q.mosi_s[1];

    always_comb begin
        fe_d        = fe_q;
        fe_d.sclk_s = {fe_q.sclk_s[1:0], sclk_i};
        fe_d.cs_s   = {fe_q.cs_s[0], cs_n_i};
        fe_d.mosi_s = {fe_q.mosi_s[0], mosi_i};
        fe_d.rd_stb = 1'b0;
        fe_d.wr_stb = 1'b0;
        if (!selected) begin
            fe_d.bitcnt = '0;
            fe_d.miso   = 1'b0;
            fe_d.shout  = '0;
        end else begin
            if (sck_rise && fe_q.bitcnt < BC_W'(FRAME_BITS)) begin
                fe_d.shin   = {fe_q.shin[BYTE_W-3:0], mosi_b};
                fe_d.bitcnt = fe_q.bitcnt + 1'b1;
                if (fe_q.bitcnt == BC_W'(BYTE_W - 1)) begin
                    fe_d.addr   = {fe_q.shin, mosi_b};
                    fe_d.rd_stb = ~fe_q.shin[BYTE_W-2];
                end
                if (fe_q.bitcnt == BC_W'(FRAME_BITS - 1) && fe_q.addr[BYTE_W-1]) begin
                    fe_d.wdata  = {fe_q.shin, mosi_b};
                    fe_d.wr_stb = 1'b1;
                end
            end
            if (sck_fall && fe_q.bitcnt >= BC_W'(BYTE_W) && fe_q.bitcnt < BC_W'(FRAME_BITS)) begin
                fe_d.miso  = fe_q.shout[BYTE_W-1];
                fe_d.shout = {fe_q.shout[BYTE_W-2:0], 1'b0};
            end
        end
        if (fe_q.rd_stb) fe_d.shout = rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fe_q <= FE_RST;
        else        fe_q <= fe_d;
    end

    assign miso_o   = fe_q.miso;
    assign rd_stb_o = fe_q.rd_stb;
    assign wr_stb_o = fe_q.wr_stb;
    assign addr_o   = fe_q.addr[ADDR_W-1:0];
    assign wdata_o  = fe_q.wdata;

    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_q.rd_stb && fe_q.wr_stb));
    p_read_at_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fe_q.rd_stb |-> (fe_q.bitcnt == BC_W'(BYTE_W)));
    p_write_full_frame_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fe_q.wr_stb |-> (fe_q.bitcnt == BC_W'(FRAME_BITS) && fe_q.addr[BYTE_W-1]));
endmodule

// File: rtl/uart_spi_regfile.sv
module uart_spi_regfile
    import uart_spi_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              tx_push_o,
    input  logic [CNT_W-1:0]  tx_cnt_i,
    output logic              rx_pop_o,
    input  logic [CNT_W-1:0]  rx_cnt_i,
    input  logic [BYTE_W-1:0] rx_head_i,
    output logic              fifo_clr_o,
    input  logic              line_evt_i,
    input  logic [BYTE_W-1:0] spc_evt_i,
    input  logic [BYTE_W-1:0] gen_evt_i,
    input  logic              cts_evt_i,
    output logic              irq_n_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] irq_en;
        logic [BYTE_W-1:0] irq_sts;
        logic [BYTE_W-1:0] spc_sts;
        logic [BYTE_W-1:0] gen_sts;
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] trig;
        logic              prev_tx_empty;
        logic              prev_rx_empty;
        logic              prev_rx_hit;
        logic              prev_tx_low;
    } reg_state_t;

    localparam reg_state_t REGS_RST = '{irq_en: '0, irq_sts: '0, spc_sts: '0, gen_sts: '0,
                                        mode: '0, trig: '0, prev_tx_empty: 1'b1,
                                        prev_rx_empty: 1'b1, prev_rx_hit: 1'b0,
                                        prev_tx_low: 1'b0};

    reg_state_t rf_d, rf_q;

    logic [3:0]        tx_nib, rx_nib;
    logic [CNT_W-1:0]  tx_thr, rx_thr;
    logic              tx_empty, rx_empty, tx_low, rx_hit;
    logic              rd_irq, rd_spc, rd_gen, soft_rst;
    logic [BYTE_W-1:0] set_irq;

    assign tx_nib   = rf_q.trig[3:0];
    assign rx_nib   = rf_q.trig[7:4];
    assign tx_thr   = CNT_W'(tx_nib) << TRIG_SH;
    assign rx_thr   = CNT_W'(rx_nib) << TRIG_SH;
    assign tx_empty = (tx_cnt_i == '0);
    assign rx_empty = (rx_cnt_i == '0);
    assign tx_low   = (tx_nib != '0) && (tx_cnt_i <= tx_thr);
    assign rx_hit   = (rx_nib != '0) && (rx_cnt_i >= rx_thr);

    assign rd_irq   = rd_stb_i && (addr_i == A_IRQ_STS);
    assign rd_spc   = rd_stb_i && (addr_i == A_SPC_STS);
    assign rd_gen   = rd_stb_i && (addr_i == A_GEN_STS);
    assign soft_rst = wr_stb_i && (addr_i == A_MODE) && wdata_i[MB_SOFT_RST];

    assign set_irq = {cts_evt_i,
                      rx_empty & ~rf_q.prev_rx_empty,
                      tx_empty & ~rf_q.prev_tx_empty,
                      tx_low   & ~rf_q.prev_tx_low,
                      rx_hit   & ~rf_q.prev_rx_hit,
                      |gen_evt_i,
                      |spc_evt_i,
                      line_evt_i};

    always_comb begin
        rf_d               = rf_q;
        rf_d.prev_tx_empty = tx_empty;
        rf_d.prev_rx_empty = rx_empty;
        rf_d.prev_rx_hit   = rx_hit;
        rf_d.prev_tx_low   = tx_low;
        rf_d.irq_sts = (rd_irq ? '0 : rf_q.irq_sts) | set_irq;
        rf_d.spc_sts = (rd_spc ? '0 : rf_q.spc_sts) | spc_evt_i;
        rf_d.gen_sts = (rd_gen ? '0 : rf_q.gen_sts) | gen_evt_i;
        if (wr_stb_i) begin
            unique case (addr_i)
                A_IRQ_EN: rf_d.irq_en = wdata_i;
                A_MODE:   rf_d.mode   = wdata_i & ~(BYTE_W'(1) << MB_SOFT_RST);
                A_TRIG:   rf_d.trig   = wdata_i;
                default:  ;
            endcase
        end
        if (soft_rst) rf_d = REGS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= REGS_RST;
        else        rf_q <= rf_d;
    end

    always_comb begin
        unique case (addr_i)
            A_DATA:    rdata_o = rx_empty ? '0 : rx_head_i;
            A_IRQ_EN:  rdata_o = rf_q.irq_en;
            A_IRQ_STS: rdata_o = rf_q.irq_sts;
            A_SPC_STS: rdata_o = rf_q.spc_sts;
            A_GEN_STS: rdata_o = rf_q.gen_sts;
            A_MODE:    rdata_o = rf_q.mode;
            A_TRIG:    rdata_o = rf_q.trig;
            A_TX_LVL:  rdata_o = BYTE_W'(tx_cnt_i);
            A_RX_LVL:  rdata_o = BYTE_W'(rx_cnt_i);
            default:   rdata_o = '0;
        endcase
    end

    assign tx_push_o  = wr_stb_i && (addr_i == A_DATA);
    assign rx_pop_o   = rd_stb_i && (addr_i == A_DATA);
    assign fifo_clr_o = soft_rst || rf_q.mode[MB_FIFO_CLR];
    assign irq_n_o    = ~|(rf_q.irq_sts & rf_q.irq_en);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_irq && set_irq == '0) |=> (rf_q.irq_sts == '0));
    p_enable_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && addr_i == A_IRQ_EN) |=> (rf_q.irq_en == $past(wdata_i)));
    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && (addr_i == A_TX_LVL || addr_i == A_RX_LVL || addr_i == A_IRQ_STS))
        |=> ($stable(rf_q.irq_en) && $stable(rf_q.mode) && $stable(rf_q.trig)));
    p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rf_q.irq_en == '0 && rf_q.trig == '0 && rf_q.mode == '0 && rf_q.irq_sts == '0));
endmodule

// File: rtl/uart_spi_bridge.sv
module uart_spi_bridge
    import uart_spi_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_take_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_put_i,
    input  logic              line_evt_i,
    input  logic [BYTE_W-1:0] spc_evt_i,
    input  logic [BYTE_W-1:0] gen_evt_i,
    input  logic              cts_evt_i,
    output logic              irq_n_o
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

    logic              rd_stb, wr_stb, tx_push, rx_pop, fifo_clr;
    logic [ADDR_W-1:0] reg_addr;
    logic [BYTE_W-1:0] wdata, rdata, rx_head;
    logic [LVL_W-1:0]  tx_cnt, rx_cnt;

    uart_spi_frontend u_fe (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (spi_sclk),
        .cs_n_i   (spi_cs_n),
        .mosi_i   (spi_mosi),
        .miso_o   (spi_miso),
        .rd_stb_o (rd_stb),
        .wr_stb_o (wr_stb),
        .addr_o   (reg_addr),
        .wdata_o  (wdata),
        .rdata_i  (rdata)
    );

    uart_spi_regfile #(.CNT_W(LVL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb_i   (rd_stb),
        .wr_stb_i   (wr_stb),
        .addr_i     (reg_addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .tx_push_o  (tx_push),
        .tx_cnt_i   (tx_cnt),
        .rx_pop_o   (rx_pop),
        .rx_cnt_i   (rx_cnt),
        .rx_head_i  (rx_head),
        .fifo_clr_o (fifo_clr),
        .line_evt_i (line_evt_i),
        .spc_evt_i  (spc_evt_i),
        .gen_evt_i  (gen_evt_i),
        .cts_evt_i  (cts_evt_i),
        .irq_n_o    (irq_n_o)
    );

    uart_spi_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (fifo_clr),
        .push_i (tx_push),
        .pop_i  (tx_take_i),
        .din_i  (wdata),
        .dout_o (tx_data_o),
        .cnt_o  (tx_cnt)
    );

    uart_spi_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (fifo_clr),
        .push_i (rx_put_i),
        .pop_i  (rx_pop),
        .din_i  (rx_data_i),
        .dout_o (rx_head),
        .cnt_o  (rx_cnt)
    );

    assign tx_valid_o = (tx_cnt != '0);
endmodule

// File: tb/uart_spi_bridge_tb.sv
module uart_spi_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;
    localparam int NV         = 16;
    // {write, addr, data, expected read}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h01, 8'hA5, 8'h00},
        {1'b0, 8'h01, 8'h00, 8'hA5},
        {1'b1, 8'h10, 8'h21, 8'h00},
        {1'b0, 8'h10, 8'h00, 8'h21},
        {1'b1, 8'h11, 8'h55, 8'h00},
        {1'b0, 8'h11, 8'h00, 8'h00},
        {1'b1, 8'h12, 8'h7F, 8'h00},
        {1'b0, 8'h12, 8'h00, 8'h00},
        {1'b0, 8'h05, 8'h00, 8'h00},
        {1'b0, 8'h7F, 8'h00, 8'h00},
        {1'b1, 8'h00, 8'h3C, 8'h00},
        {1'b1, 8'h00, 8'hC3, 8'h00},
        {1'b0, 8'h11, 8'h00, 8'h02},
        {1'b1, 8'h01, 8'h00, 8'h00},
        {1'b1, 8'h10, 8'h00, 8'h00},
        {1'b0, 8'h10, 8'h00, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
    logic [7:0] tx_data, rx_data = '0, spc_evt = '0, gen_evt = '0;
    logic tx_valid, tx_take = 1'b0, rx_put = 1'b0, line_evt = 1'b0, cts_evt = 1'b0, irq_n;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_spi_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_take_i(tx_take),
        .rx_data_i(rx_data), .rx_put_i(rx_put), .line_evt_i(line_evt), .spc_evt_i(spc_evt),
        .gen_evt_i(gen_evt), .cts_evt_i(cts_evt), .irq_n_o(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input logic [7:0] a, input logic [7:0] d, input int nbits,
                             output logic [7:0] r);
        logic [15:0] f;
        f = {a, d};
        r = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 15; i >= 16 - nbits; i--) begin
            mosi = f[i];
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
            if (i < 8) r = {r[6:0], miso};
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] unused;
        spi_frame({1'b1, a}, d, 16, unused);
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] r;
        spi_frame({1'b0, a}, 8'h00, 16, r);
        check(req, r, exp);
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        rx_data = d;
        rx_put  = 1'b1;
        @(negedge clk);
        rx_put  = 1'b0;
    endtask

    task automatic tx_pop();
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R14 reset state
        check("R14 irq_n", {7'd0, irq_n}, 8'h01);
        check("R14 tx_valid", {7'd0, tx_valid}, 8'h00);
        rd_chk("R14 R5 tx level", 7'h11, 8'h00);
        rd_chk("R14 R5 rx level", 7'h12, 8'h00);
        rd_chk("R14 mode", 7'h0a, 8'h00);
        rd_chk("R14 status", 7'h02, 8'h00);

        // R1 R2 R6 vector table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][24]) wr(VEC[v][22:16], VEC[v][15:8]);
            else rd_chk($sformatf("R1 R6 table[%0d]", v), VEC[v][22:16], VEC[v][7:0]);
        end

        // R2 transmit order
        check("R2 valid", {7'd0, tx_valid}, 8'h01);
        check("R2 head0", tx_data, 8'h3C);
        tx_pop();
        check("R2 head1", tx_data, 8'hC3);
        tx_pop();
        check("R2 drained", {7'd0, tx_valid}, 8'h00);

        // R7 clear on read; R8 bits 4 and 5
        rd_chk("R7 R8 status", 7'h02, 8'h30);
        rd_chk("R7 cleared", 7'h02, 8'h00);
        // R6 read-only status writes
        wr(7'h02, 8'hFF);
        wr(7'h06, 8'hFF);
        rd_chk("R6 ro 0x02", 7'h02, 8'h00);
        rd_chk("R6 ro 0x06", 7'h06, 8'h00);

        // R3 receive order, R4 empty read
        rx_push(8'h11);
        rx_push(8'h22);
        rx_push(8'h33);
        rd_chk("R5 rx level", 7'h12, 8'h03);
        rd_chk("R3 pop0", 7'h00, 8'h11);
        rd_chk("R3 pop1", 7'h00, 8'h22);
        rd_chk("R3 pop2", 7'h00, 8'h33);
        rd_chk("R4 empty read", 7'h00, 8'h00);
        rd_chk("R4 level", 7'h12, 8'h00);
        rd_chk("R8 rx empty bit", 7'h02, 8'h40);

        // R10 receive trigger
        wr(7'h10, 8'h10);
        for (int i = 0; i < 7; i++) rx_push(8'(i));
        rd_chk("R10 below rx trig", 7'h02, 8'h00);
        rx_push(8'h07);
        rd_chk("R10 rx trig", 7'h02, 8'h08);

        // R11 queue clear held
        wr(7'h0a, 8'h02);
        rd_chk("R11 mode readback", 7'h0a, 8'h02);
        rd_chk("R11 rx cleared", 7'h12, 8'h00);
        rx_push(8'h99);
        rd_chk("R11 rx held", 7'h12, 8'h00);
        wr(7'h0a, 8'h00);
        rd_chk("R11 R8 rx empty", 7'h02, 8'h40);
        wr(7'h10, 8'h00);

        // R10 transmit trigger
        wr(7'h10, 8'h01);
        rd_chk("R10 tx trig", 7'h02, 8'h10);
        wr(7'h10, 8'h00);

        // R8 event collection
        @(negedge clk);
        line_evt = 1'b1; spc_evt = 8'h05; gen_evt = 8'h80; cts_evt = 1'b1;
        @(negedge clk);
        line_evt = 1'b0; spc_evt = 8'h00; gen_evt = 8'h00; cts_evt = 1'b0;
        rd_chk("R8 master status", 7'h02, 8'h87);
        rd_chk("R8 special", 7'h06, 8'h05);
        rd_chk("R7 special cleared", 7'h06, 8'h00);
        rd_chk("R8 general", 7'h08, 8'h80);
        rd_chk("R7 master cleared", 7'h02, 8'h00);

        // R9 interrupt masking
        wr(7'h01, 8'h80);
        @(negedge clk); line_evt = 1'b1; @(negedge clk); line_evt = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 masked", {7'd0, irq_n}, 8'h01);
        @(negedge clk); cts_evt = 1'b1; @(negedge clk); cts_evt = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 asserted", {7'd0, irq_n}, 8'h00);
        rd_chk("R9 status", 7'h02, 8'h81);
        check("R9 released", {7'd0, irq_n}, 8'h01);

        // R13 aborted frame
        begin
            logic [7:0] unused;
            spi_frame(8'h81, 8'h00, 11, unused);
        end
        rd_chk("R13 abort", 7'h01, 8'h80);

        // R5 full transmit queue
        for (int i = 0; i < 130; i++) wr(7'h00, 8'(i));
        rd_chk("R5 full level", 7'h11, 8'h80);
        check("R5 head", tx_data, 8'h00);
        for (int i = 0; i < 127; i++) tx_pop();
        check("R5 last kept", tx_data, 8'h7F);
        tx_pop();
        check("R5 no extra", {7'd0, tx_valid}, 8'h00);

        // R12 soft reset
        wr(7'h01, 8'hFF);
        wr(7'h10, 8'h33);
        wr(7'h00, 8'hAA);
        wr(7'h0a, 8'h01);
        check("R12 tx emptied", {7'd0, tx_valid}, 8'h00);
        check("R12 irq", {7'd0, irq_n}, 8'h01);
        rd_chk("R12 enable", 7'h01, 8'h00);
        rd_chk("R12 trig", 7'h10, 8'h00);
        rd_chk("R12 mode", 7'h0a, 8'h00);
        rd_chk("R12 tx level", 7'h11, 8'h00);
        rd_chk("R12 status", 7'h02, 8'h00);

        finish_run();
    end
endmodule